// File: doc/BRIEF.md
# Event counter unit with overflow status

This block counts hardware events for performance sampling. It has a parameterised set of general counters and up to three fixed-function counters. A general counter follows one of several event lines, and a per-counter select word chooses which one. The fixed counters follow dedicated lines for retired instructions, core cycles and bus cycles. Every counter is also gated by a privilege qualifier. The `user_mode` input is 1 in user mode and 0 in kernel mode, and each counter can be allowed to count in either mode, in both or in neither.

Software programs the unit through a plain register bus. To sample every P events, it loads a counter with the two's complement of P, taken to the counter width. The counter then rolls over to zero on exactly the P-th event. The rollover sets a sticky status bit, and if that counter's interrupt enable is set, it raises `irq`. A single global enable register gates every counter at once. Writing it to zero and later writing back the saved value pauses and resumes all counting without losing any per-counter setting.

Register map (6-bit word addresses, 64-bit data): select word of general counter i at 0x00+i; general counter value i at 0x08+i; fixed counter value j at 0x10+j; fixed control at 0x18; global enable at 0x19; global status at 0x1A (read only); overflow clear at 0x1B (write only, reads 0).

Top module: `evcnt_unit`

## Requirements
- R1: After reset, every counter, select word, the fixed control, the global enable, the status, `bus_rdata` and `irq` are all zero.
- R2: A write with `bus_we` high takes effect at the clock edge. `bus_rdata` shows the register addressed at one edge after that edge. A select word keeps only the bits in mask 0xFF53FFFF. The global enable keeps only bits 0..NUM_GEN-1 and bits 32..32+NUM_FIX-1.
- R3: A write to a counter keeps only the low CNT_W bits of the data.
- R4: General counter i adds one on each edge when all of the following hold: select bit 22 (enable) is set; global enable bit i is set; the event line chosen by select bits 7:0 is high; and the privilege bit for the current mode is set. That bit is bit 16 when `user_mode`=1 and bit 17 when `user_mode`=0. A code of EVT_N or more counts nothing.
- R5: Fixed counter j is controlled by the 4-bit field at bits 4j+3..4j of the fixed control. Field bit 1 allows counting in user mode and bit 0 allows counting in kernel mode. The counter counts `fix_evt[j]` only while global enable bit 32+j is set. A zero field stops the counter.
- R6: A counter holding all ones that counts an event becomes zero and sets its status bit. A counter preloaded with 2^CNT_W-P therefore rolls over on exactly the P-th event.
- R7: Status bit i belongs to general counter i and status bit 32+j belongs to fixed counter j. Status bits are sticky, and writes to the status address have no effect.
- R8: Writing a mask to the overflow-clear address clears the matching status bits. A rollover in the same cycle keeps its bit set.
- R9: `irq` is high exactly while some status bit is set whose interrupt enable is also set. For a general counter the enable is select bit 20; for a fixed counter it is field bit 3.
- R10: Writing 0 to the global enable stops every counter. Writing back the earlier value restores exactly the earlier enables, and counting resumes.
- R11: A software write to a counter in the same cycle as a counted event wins: the counter takes the written value and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 64 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 64 | Read data, one cycle after the address |
| user_mode | input | 1 | 1 = user mode, 0 = kernel mode |
| gen_evt | input | EVT_N | Event lines selectable by general counters |
| fix_evt | input | NUM_FIX | Fixed events: 0 retired instructions, 1 core cycles, 2 bus cycles |
| irq | output | 1 | Overflow interrupt |

## Verification
A counter that drops or adds a count shows up in the value read back one cycle after its address. A wrongly qualified enable shows up the same way, and it also moves the cycle of the rollover, so `irq` and the status rise one event early or late, on the very edge where the wrong count lands. A status bit that is lost, or cleared by the wrong mask, is visible at the next status read and at `irq` in the cycle right after. Because of that, every rollover test samples status and `irq` right after the exact event that should trigger it and right after the event before it.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int DW = 64;
  localparam int AW = 6;
  localparam int FIX_OFS = 32;

  // general select word bit positions
  localparam int SEL_USR_BIT = 16;
  localparam int SEL_KRN_BIT = 17;
  localparam int SEL_INT_BIT = 20;
  localparam int SEL_EN_BIT  = 22;
  localparam logic [31:0] SEL_KEEP = 32'hFF53_FFFF;

  // fixed-control field bit positions
  localparam int FLD_KRN = 0;
  localparam int FLD_USR = 1;
  localparam int FLD_INT = 3;

  // register map
  localparam logic [AW-1:0] A_SEL   = 6'h00;
  localparam logic [AW-1:0] A_GCNT  = 6'h08;
  localparam logic [AW-1:0] A_FCNT  = 6'h10;
  localparam logic [AW-1:0] A_FCTL  = 6'h18;
  localparam logic [AW-1:0] A_GCTL  = 6'h19;
  localparam logic [AW-1:0] A_GSTAT = 6'h1A;
  localparam logic [AW-1:0] A_OVCLR = 6'h1B;

  // privilege qualifier: which permission applies in the current mode
  function automatic logic mode_ok(input logic in_user, input logic usr_en,
                                   input logic krn_en);
    return in_user ? usr_en : krn_en;
  endfunction

  // implemented bits of the enable / status layout
  function automatic logic [DW-1:0] slot_mask(input int ng, input int nf);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < ng; i++) m[i] = 1'b1;
    for (int j = 0; j < nf; j++) m[FIX_OFS+j] = 1'b1;
    return m;
  endfunction

  // rollover condition of a counter of width w
  function automatic logic rolls(input logic [DW-1:0] v, input int w);
    logic [DW-1:0] ones;
    ones = (w >= DW) ? '1 : ((DW'(1) << w) - DW'(1));
    return (v & ones) == ones;
  endfunction
endpackage

// File: rtl/evcnt_ctr.sv
module evcnt_ctr
  import evcnt_pkg::*;
#(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wval,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         wrap
);
  // software write has priority over a counted event
  assign wrap = inc && !wr && rolls(DW'(val), W);

  always_ff @(posedge clk) begin
    if (!rst_n)   val <= '0;
    else if (wr)  val <= wval;
    else if (inc) val <= val + W'(1);
  end
endmodule

// File: rtl/evcnt_status.sv
module evcnt_status #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] int_en,
  output logic [N-1:0] status_q,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_mask : '0;

  // a rollover in the clearing cycle keeps its bit
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_eff) | set_vec;
  end

  assign irq = |(status_q & int_en);
endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit
  import evcnt_pkg::*;
#(
  parameter int NUM_GEN = 4,
  parameter int NUM_FIX = 3,
  parameter int CNT_W   = 48,
  parameter int EVT_N   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               bus_we,
  output logic [DW-1:0]      bus_rdata,
  input  logic               user_mode,
  input  logic [EVT_N-1:0]   gen_evt,
  input  logic [NUM_FIX-1:0] fix_evt,
  output logic               irq
);
  localparam int FCTL_W = 4 * NUM_FIX;
  localparam int EIW    = (EVT_N > 1) ? $clog2(EVT_N) : 1;
  localparam int NCTR   = NUM_GEN + NUM_FIX;
  localparam logic [DW-1:0] SLOT_MASK = slot_mask(NUM_GEN, NUM_FIX);

  logic [31:0]       sel_q  [NUM_GEN];
  logic [CNT_W-1:0]  gcnt   [NUM_GEN];
  logic [CNT_W-1:0]  fcnt   [NUM_FIX];
  logic [NUM_GEN-1:0] inc_g, wrap_g, inten_g;
  logic [NUM_FIX-1:0] inc_f, wrap_f, inten_f;
  logic [FCTL_W-1:0] fctl_q;
  logic [DW-1:0]     gctl_q;
  logic [DW-1:0]     inc_vec, wrap_vec, inten_vec, status_q, rd_next;
  logic [NCTR*CNT_W-1:0] cnt_flat;
  logic              clr_wr;
  logic [DW-1:0]     clr_mask;

  assign clr_wr   = bus_we && (bus_addr == A_OVCLR);
  assign clr_mask = bus_wdata;

  // general counters
  for (genvar i = 0; i < NUM_GEN; i++) begin : g_gen
    logic [31:0] sel_r;
    logic        wr_sel, wr_cnt, hit;

    assign wr_sel = bus_we && (bus_addr == A_SEL + AW'(i));
    assign wr_cnt = bus_we && (bus_addr == A_GCNT + AW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)      sel_r <= '0;
      else if (wr_sel) sel_r <= bus_wdata[31:0] & SEL_KEEP;
    end

    assign hit = (sel_r[7:0] < 8'(EVT_N)) && gen_evt[sel_r[EIW-1:0]];
    assign inc_g[i] = sel_r[SEL_EN_BIT] && gctl_q[i] && hit &&
                      mode_ok(user_mode, sel_r[SEL_USR_BIT], sel_r[SEL_KRN_BIT]);
    assign inten_g[i] = sel_r[SEL_INT_BIT];
    assign sel_q[i]   = sel_r;

    evcnt_ctr #(.W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (wr_cnt),
      .wval (bus_wdata[CNT_W-1:0]),
      .inc  (inc_g[i]),
      .val  (gcnt[i]),
      .wrap (wrap_g[i])
    );
  end

  // fixed counters
  for (genvar j = 0; j < NUM_FIX; j++) begin : g_fix
    logic [3:0] fld;
    logic       wr_cnt;

    assign fld    = fctl_q[4*j +: 4];
    assign wr_cnt = bus_we && (bus_addr == A_FCNT + AW'(j));
    assign inc_f[j] = gctl_q[FIX_OFS+j] && fix_evt[j] &&
                      mode_ok(user_mode, fld[FLD_USR], fld[FLD_KRN]);
    assign inten_f[j] = fld[FLD_INT];

    evcnt_ctr #(.W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (wr_cnt),
      .wval (bus_wdata[CNT_W-1:0]),
      .inc  (inc_f[j]),
      .val  (fcnt[j]),
      .wrap (wrap_f[j])
    );
  end

  // control registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fctl_q <= '0;
      gctl_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_FCTL) fctl_q <= bus_wdata[FCTL_W-1:0];
      if (bus_addr == A_GCTL) gctl_q <= bus_wdata & SLOT_MASK;
    end
  end

  // status layout vectors
  always_comb begin
    inc_vec   = '0;
    wrap_vec  = '0;
    inten_vec = '0;
    cnt_flat  = '0;
    for (int i = 0; i < NUM_GEN; i++) begin
      inc_vec[i]   = inc_g[i];
      wrap_vec[i]  = wrap_g[i];
      inten_vec[i] = inten_g[i];
      cnt_flat[i*CNT_W +: CNT_W] = gcnt[i];
    end
    for (int j = 0; j < NUM_FIX; j++) begin
      inc_vec[FIX_OFS+j]   = inc_f[j];
      wrap_vec[FIX_OFS+j]  = wrap_f[j];
      inten_vec[FIX_OFS+j] = inten_f[j];
      cnt_flat[(NUM_GEN+j)*CNT_W +: CNT_W] = fcnt[j];
    end
  end

  evcnt_status #(.N(DW)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (wrap_vec),
    .clr_wr  (clr_wr),
    .clr_mask(clr_mask),
    .int_en  (inten_vec),
    .status_q(status_q),
    .irq     (irq)
  );

  // read path, one cycle latency
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_GEN; i++) begin
      if (bus_addr == A_SEL + AW'(i))  rd_next = DW'(sel_q[i]);
      if (bus_addr == A_GCNT + AW'(i)) rd_next = DW'(gcnt[i]);
    end
    for (int j = 0; j < NUM_FIX; j++)
      if (bus_addr == A_FCNT + AW'(j)) rd_next = DW'(fcnt[j]);
    if (bus_addr == A_FCTL)  rd_next = DW'(fctl_q);
    if (bus_addr == A_GCTL)  rd_next = gctl_q;
    if (bus_addr == A_GSTAT) rd_next = status_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end
endmodule

// File: rtl/evcnt_unit_chk.sv
module evcnt_unit_chk #(
  parameter int DW  = 64,
  parameter int CFW = 336
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_we,
  input logic           clr_wr,
  input logic [DW-1:0]  clr_mask,
  input logic [DW-1:0]  wrap_vec,
  input logic [DW-1:0]  status_q,
  input logic [DW-1:0]  gctl_q,
  input logic [CFW-1:0] cnt_flat,
  input logic           irq
);
  // R7: status bits only drop through the clear register
  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R6 / R8: every rollover lands in status, even against a clear
  assert_wrap_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_vec != '0) |=> ((status_q & $past(wrap_vec)) == $past(wrap_vec)));

  // R8: cleared bits are gone the next cycle when nothing rolls over
  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && wrap_vec == '0) |=> ((status_q & $past(clr_mask)) == '0));

  // R9: no interrupt without a pending status bit
  assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq);

  // R10: with global enable at zero and no writes, counters hold
  assert_global_off_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gctl_q == '0 && !bus_we) |=> $stable(cnt_flat));
endmodule

bind evcnt_unit evcnt_unit_chk #(
  .DW (evcnt_pkg::DW),
  .CFW((NUM_GEN + NUM_FIX) * CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_we  (bus_we),
  .clr_wr  (clr_wr),
  .clr_mask(clr_mask),
  .wrap_vec(wrap_vec),
  .status_q(status_q),
  .gctl_q  (gctl_q),
  .cnt_flat(cnt_flat),
  .irq     (irq)
);

// File: tb/evcnt_unit_bench.sv
module evcnt_unit_bench;
  import evcnt_pkg::*;

  localparam int NG = 4, NF = 3, CW = 48, NE = 8;
  localparam logic [DW-1:0] TOP = (DW'(1) << CW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          user_mode = 1'b1;
  logic [NE-1:0] gen_evt = '0;
  logic [NF-1:0] fix_evt = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] rv, saved;

  always #5 clk = ~clk;

  evcnt_unit #(.NUM_GEN(NG), .NUM_FIX(NF), .CNT_W(CW), .EVT_N(NE)) u_evcnt_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .user_mode(user_mode),
    .gen_evt(gen_evt), .fix_evt(fix_evt), .irq(irq)
  );

  typedef struct packed {
    logic        usr;
    logic [31:0] sel;
    logic [2:0]  line;
    logic [7:0]  pulses;
    logic [7:0]  exp;
  } vec_t;

  // general counter 0 qualification patterns (R4)
  localparam vec_t VEC [0:6] = '{
    '{1'b1, 32'h0041_0000, 3'd0, 8'd5, 8'd5},
    '{1'b0, 32'h0041_0000, 3'd0, 8'd5, 8'd0},
    '{1'b0, 32'h0042_0000, 3'd0, 8'd5, 8'd5},
    '{1'b1, 32'h0003_0000, 3'd0, 8'd4, 8'd0},
    '{1'b1, 32'h0041_0003, 3'd0, 8'd4, 8'd0},
    '{1'b1, 32'h0041_0003, 3'd3, 8'd7, 8'd7},
    '{1'b1, 32'h0041_0009, 3'd1, 8'd6, 8'd0}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic gpulse(input int line, input int n);
    @(negedge clk);
    gen_evt = NE'(1) << line;
    repeat (n) @(negedge clk);
    gen_evt = '0;
  endtask

  task automatic fpulse(input int j, input int n);
    @(negedge clk);
    fix_evt = NF'(1) << j;
    repeat (n) @(negedge clk);
    fix_evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", bus_rdata, '0);
    chk("R1 irq", DW'(irq), '0);
    rd(A_GSTAT, rv);  chk("R1 status", rv, '0);
    rd(A_GCNT, rv);   chk("R1 gcnt0", rv, '0);
    rd(A_SEL, rv);    chk("R1 sel0", rv, '0);
    rd(A_GCTL, rv);   chk("R1 gctl", rv, '0);
    rd(A_FCNT+6'd2, rv); chk("R1 fcnt2", rv, '0);

    // R2 register masking
    wr(A_SEL+6'd2, '1);
    rd(A_SEL+6'd2, rv); chk("R2 sel mask", rv, 64'h0000_0000_FF53_FFFF);
    wr(A_SEL+6'd2, '0);
    wr(A_GCTL, '1);
    rd(A_GCTL, rv); chk("R2 gctl mask", rv, 64'h0000_0007_0000_000F);
    // R3 counter write width
    wr(A_GCNT+6'd2, '1);
    rd(A_GCNT+6'd2, rv); chk("R3 cnt mask", rv, TOP - 1);

    // R4 table of qualification patterns
    wr(A_GCTL, 64'h1);
    for (int k = 0; k < 7; k++) begin
      wr(A_SEL, DW'(VEC[k].sel));
      wr(A_GCNT, '0);
      user_mode = VEC[k].usr;
      gpulse(int'(VEC[k].line), int'(VEC[k].pulses));
      rd(A_GCNT, rv);
      chk($sformatf("R4 vector %0d", k), rv, DW'(VEC[k].exp));
    end

    // R6 / R9 rollover on exactly the period
    user_mode = 1'b1;
    wr(A_SEL, 64'h0051_0000);
    wr(A_GCNT, TOP - 3);
    gpulse(0, 2);
    rd(A_GSTAT, rv); chk("R6 no early status", rv, '0);
    chk("R9 no early irq", DW'(irq), '0);
    gpulse(0, 1);
    chk("R9 irq on wrap", DW'(irq), 64'h1);
    rd(A_GSTAT, rv); chk("R6 status on wrap", rv, 64'h1);
    rd(A_GCNT, rv);  chk("R6 wrapped to zero", rv, '0);

    // R7 status is read-only, R8 clear by mask
    wr(A_GSTAT, '0);
    rd(A_GSTAT, rv); chk("R7 status write ignored", rv, 64'h1);
    wr(A_OVCLR, 64'h2);
    rd(A_GSTAT, rv); chk("R8 other bit clear", rv, 64'h1);
    wr(A_OVCLR, 64'h1);
    rd(A_GSTAT, rv); chk("R8 cleared", rv, '0);
    chk("R9 irq dropped", DW'(irq), '0);

    // R9 no interrupt enable
    wr(A_SEL, 64'h0041_0000);
    wr(A_GCNT, TOP - 1);
    gpulse(0, 1);
    rd(A_GSTAT, rv); chk("R9 status without int", rv, 64'h1);
    chk("R9 irq masked", DW'(irq), '0);

    // R8 rollover during a clear keeps its bit
    wr(A_GCNT, TOP - 1);
    @(negedge clk);
    gen_evt = 8'h01; bus_addr = A_OVCLR; bus_wdata = 64'h1; bus_we = 1'b1;
    @(negedge clk);
    gen_evt = '0; bus_we = 1'b0;
    rd(A_GSTAT, rv); chk("R8 set wins", rv, 64'h1);
    wr(A_OVCLR, 64'h1);

    // R11 write beats event
    wr(A_GCNT, TOP - 1);
    @(negedge clk);
    gen_evt = 8'h01; bus_addr = A_GCNT; bus_wdata = 64'h5; bus_we = 1'b1;
    @(negedge clk);
    gen_evt = '0; bus_we = 1'b0;
    rd(A_GCNT, rv);  chk("R11 written value", rv, 64'h5);
    rd(A_GSTAT, rv); chk("R11 no status", rv, '0);

    // R10 global pause and restore
    wr(A_FCTL, 64'h020);
    wr(A_GCNT, '0);
    wr(A_FCNT+6'd1, '0);
    saved = 64'h0000_0007_0000_000F;
    wr(A_GCTL, saved);
    wr(A_GCTL, '0);
    gpulse(0, 3); fpulse(1, 3);
    rd(A_GCNT, rv);      chk("R10 gen paused", rv, '0);
    rd(A_FCNT+6'd1, rv); chk("R10 fix paused", rv, '0);
    wr(A_GCTL, saved);
    rd(A_GCTL, rv);      chk("R10 restored", rv, saved);
    gpulse(0, 3); fpulse(1, 2);
    rd(A_GCNT, rv);      chk("R10 gen resumed", rv, 64'h3);
    rd(A_FCNT+6'd1, rv); chk("R10 fix resumed", rv, 64'h2);

    // R5 fixed field qualification
    wr(A_FCNT+6'd1, '0);
    user_mode = 1'b0;
    fpulse(1, 4);
    rd(A_FCNT+6'd1, rv); chk("R5 user-only in kernel", rv, '0);
    wr(A_FCTL, 64'h010);
    fpulse(1, 4);
    rd(A_FCNT+6'd1, rv); chk("R5 kernel counts", rv, 64'h4);
    fpulse(2, 4);
    rd(A_FCNT+6'd1, rv); chk("R5 own line only", rv, 64'h4);
    wr(A_FCTL, '0);
    fpulse(1, 4);
    rd(A_FCNT+6'd1, rv); chk("R5 zero field stops", rv, 64'h4);

    // R6 / R7 / R9 fixed rollover at bit 33
    user_mode = 1'b1;
    wr(A_FCTL, 64'h0A0);
    wr(A_FCNT+6'd1, TOP - 2);
    fpulse(1, 2);
    chk("R9 fixed irq", DW'(irq), 64'h1);
    rd(A_GSTAT, rv);     chk("R7 fixed status bit", rv, 64'h2_0000_0000);
    rd(A_FCNT+6'd1, rv); chk("R6 fixed wrapped", rv, '0);
    wr(A_OVCLR, 64'h2_0000_0000);
    rd(A_GSTAT, rv);     chk("R8 fixed cleared", rv, '0);
    chk("R9 fixed irq low", DW'(irq), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule